// File: doc/BRIEF.md
# Serial Bus Frame Receiver

This block decodes frames arriving on a wired-AND serial bus, such as the bus used in vehicle networks. A level of 1 on `rx` means recessive and a level of 0 means dominant. A bit-timing stage outside this block pulses `bit_en` once per bit time at the sample point. On each pulse the receiver takes one bit.

A frame may start only when the bus is idle. From that point the receiver strips the stuff bits and parses the destuffed stream, in either the short-identifier or the long-identifier layout, into these fields:

- identifier
- format flag
- remote flag
- length code
- payload

The receiver recomputes the 15-bit check sum and compares it with the one sent on the bus. It also checks the fixed recessive fields. When the frame is sound up to the acknowledge slot, the receiver pulls the bus dominant in that slot, whatever the identifier is.

A correct frame ends with a one-clock `frame_ok` pulse, and the parsed fields are held on the outputs. Three other pulses report faults: `crc_err`, `form_err` and `stuff_err`. Each fault abandons the frame, and the receiver then waits for the bus to go idle again.

Top module: `busframe_rx`

## Requirements
- R1: The bus becomes idle after 11 consecutive recessive sampled bits, counted from reset or from any fault. After a good frame it becomes idle after 3 further recessive bits that follow the last end-of-frame bit. A dominant bit counts as start-of-frame only while the bus is idle.
- R2: The stuffed region runs from start-of-frame to the end of the check-sum field, and start-of-frame counts toward a run. Inside it, the bit that follows five equal bits is discarded and does not reach the parser or the check sum. This includes a stuff bit that directly follows the last check-sum bit.
- R3: The destuffed order is as follows. Eleven identifier bits come first, MSB first. One flag bit follows, then the format bit. If the format bit is 0, the frame is short: `id[10:0]` holds the identifier and `id[28:11]` is zero. If the format bit is 1, 18 more identifier bits follow, and the first 11 bits land in `id[28:18]`. `ext` equals the format bit.
- R4: `rtr` is the remote bit. In a short frame it is the bit just before the format bit. In a long frame it is the bit right after the 18 extra identifier bits. Reserved bits follow the remote bit: one in a short frame, two in a long frame. Their level is ignored.
- R5: The length code has 4 bits, MSB first, and `dlc` shows its raw value. The payload holds min(code, 8) bytes, or none for a remote frame. The first byte lands in `data[63:56]`, MSB first. Unused bytes read zero.
- R6: The check sum uses polynomial 0x4599 and starts from zero. It covers start-of-frame through the payload, MSB first, and is followed by the 15 transmitted bits. A mismatch gives one `crc_err` pulse, no acknowledge and no `frame_ok`.
- R7: The check-sum delimiter, the acknowledge delimiter and all 7 end-of-frame bits must be recessive. A dominant level in any of them gives one `form_err` pulse and no `frame_ok`.
- R8: A sixth equal bit in the stuffed region gives one `stuff_err` pulse and no `frame_ok`.
- R9: `ack_drive` is 1, meaning pull the bus dominant, from the strobe that samples a recessive check-sum delimiter up to the strobe that samples the acknowledge slot. This happens only after the check sum matched, and for any identifier.
- R10: `frame_ok` is high for exactly one clock, right after the strobe that samples the last end-of-frame bit. It occurs only in a frame without a fault, and the field outputs are valid while it is high.
- R11: At most one of `frame_ok`, `crc_err`, `form_err` and `stuff_err` is high in any clock, and each pulse follows a `bit_en` strobe. After reset all of them and `ack_drive` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-clock strobe at the bit sample point |
| rx | input | 1 | Bus level, 1 = recessive |
| ack_drive | output | 1 | 1 = pull the bus dominant (acknowledge slot) |
| frame_ok | output | 1 | Pulse: correct frame received |
| crc_err | output | 1 | Pulse: check-sum mismatch |
| form_err | output | 1 | Pulse: fixed field not recessive |
| stuff_err | output | 1 | Pulse: six equal bits in stuffed region |
| ext | output | 1 | Long-identifier frame |
| rtr | output | 1 | Remote frame |
| id | output | 29 | Identifier |
| dlc | output | 4 | Raw length code |
| data | output | 64 | Payload, first byte in the top byte |

## Verification
The properties assume that `bit_en` lasts a single clock and that strobes are spaced several clocks apart. They also assume that `rx` reflects the wired-AND of the transmitted level and the block's own `ack_drive`. The bench drives each bit for four clocks with one strobe, and it derives `rx` from its transmit level ANDed with the inverse of `ack_drive`. This means the acknowledge slot reads dominant exactly as it would on a real bus. Frames are built and stuffed arithmetically in the bench, so every stuffing pattern the bench sends is legal unless a fault is injected on purpose.

// File: rtl/busframe_rx.sv
`timescale 1ns/1ps
module busframe_rx #(
  parameter int          EOF_BITS  = 7,
  parameter int          IFS_BITS  = 3,
  parameter int          MAX_BYTES = 8,
  parameter logic [14:0] CRC_POLY  = 15'h4599
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_en,
  input  logic                     rx,
  output logic                     ack_drive,
  output logic                     frame_ok,
  output logic                     crc_err,
  output logic                     form_err,
  output logic                     stuff_err,
  output logic                     ext,
  output logic                     rtr,
  output logic [28:0]              id,
  output logic [3:0]               dlc,
  output logic [8*MAX_BYTES-1:0]   data
);
  localparam int DATA_W    = 8 * MAX_BYTES;
  localparam int DIX_W     = $clog2(DATA_W);
  localparam int CNT_W     = DIX_W + 1;
  localparam int CRC_W     = 15;
  localparam int SYNC_BITS = 1 + EOF_BITS + IFS_BITS;

  typedef enum logic [3:0] {
    S_SYNC, S_IDLE, S_IDA, S_B12, S_IDE, S_IDB, S_RTR, S_RES,
    S_DLC, S_DATA, S_CRC, S_CDL, S_ACK, S_ADL, S_EOF
  } st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        run;
  logic              last;
  logic [CRC_W-1:0]  crc;

  wire in_stuff  = (st inside {S_IDA, S_B12, S_IDE, S_IDB, S_RTR, S_RES, S_DLC, S_DATA, S_CRC})
                 || (st == S_CDL && run == 3'd5);
  wire is_stuff  = in_stuff && run == 3'd5;
  wire [CRC_W-1:0] crc_nx = {crc[CRC_W-2:0], 1'b0} ^ ((rx ^ crc[CRC_W-1]) ? CRC_POLY : '0);
  wire [3:0] dlc_nx = {dlc[2:0], rx};
  wire [3:0] nb     = (dlc > 4'(MAX_BYTES)) ? 4'(MAX_BYTES) : dlc;
  wire [CNT_W-1:0] dlast = CNT_W'({nb, 3'b000}) - CNT_W'(1);
  wire [DIX_W-1:0] dix   = DIX_W'(DATA_W - 1) - cnt[DIX_W-1:0];

  assign ack_drive = (st == S_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_SYNC; cnt <= '0; run <= '0; last <= 1'b0; crc <= '0;
      frame_ok <= 1'b0; crc_err <= 1'b0; form_err <= 1'b0; stuff_err <= 1'b0;
      ext <= 1'b0; rtr <= 1'b0; id <= '0; dlc <= '0; data <= '0;
    end else begin
      frame_ok <= 1'b0; crc_err <= 1'b0; form_err <= 1'b0; stuff_err <= 1'b0;
      if (bit_en) begin
        if (in_stuff) begin
          if (is_stuff) begin
            if (rx == last) begin
              stuff_err <= 1'b1; st <= S_SYNC; cnt <= '0;
            end else begin
              last <= rx; run <= 3'd1;
            end
          end else begin
            last <= rx;
            run  <= (rx == last) ? run + 3'd1 : 3'd1;
            crc  <= crc_nx;
          end
        end
        if (!is_stuff) begin
          case (st)
            S_SYNC: begin
              if (!rx) cnt <= '0;
              else if (cnt == CNT_W'(SYNC_BITS - 1)) st <= S_IDLE;
              else cnt <= cnt + 1'b1;
            end
            S_IDLE: if (!rx) begin
              st <= S_IDA; cnt <= '0; crc <= '0; last <= 1'b0; run <= 3'd1;
              id <= '0; data <= '0; dlc <= '0; ext <= 1'b0; rtr <= 1'b0;
            end
            S_IDA: begin
              id <= {id[27:0], rx};
              if (cnt == CNT_W'(10)) st <= S_B12; else cnt <= cnt + 1'b1;
            end
            S_B12: begin rtr <= rx; st <= S_IDE; end
            S_IDE: begin ext <= rx; cnt <= '0; st <= rx ? S_IDB : S_RES; end
            S_IDB: begin
              id <= {id[27:0], rx};
              if (cnt == CNT_W'(17)) st <= S_RTR; else cnt <= cnt + 1'b1;
            end
            S_RTR: begin rtr <= rx; cnt <= '0; st <= S_RES; end
            S_RES: begin
              if (cnt == CNT_W'(ext)) begin st <= S_DLC; cnt <= '0; end
              else cnt <= cnt + 1'b1;
            end
            S_DLC: begin
              dlc <= dlc_nx;
              if (cnt == CNT_W'(3)) begin
                cnt <= '0;
                st  <= (rtr || dlc_nx == 4'd0) ? S_CRC : S_DATA;
              end else cnt <= cnt + 1'b1;
            end
            S_DATA: begin
              data[dix] <= rx;
              if (cnt == dlast) begin st <= S_CRC; cnt <= '0; end
              else cnt <= cnt + 1'b1;
            end
            S_CRC: begin
              if (cnt == CNT_W'(CRC_W - 1)) begin
                cnt <= '0;
                if (crc_nx != '0) begin crc_err <= 1'b1; st <= S_SYNC; end
                else st <= S_CDL;
              end else cnt <= cnt + 1'b1;
            end
            S_CDL: begin
              if (rx) st <= S_ACK;
              else begin form_err <= 1'b1; st <= S_SYNC; cnt <= '0; end
            end
            S_ACK: st <= S_ADL;
            S_ADL: begin
              cnt <= '0;
              if (rx) st <= S_EOF;
              else begin form_err <= 1'b1; st <= S_SYNC; end
            end
            S_EOF: begin
              if (!rx) begin form_err <= 1'b1; st <= S_SYNC; cnt <= '0; end
              else if (cnt == CNT_W'(EOF_BITS - 1)) begin
                frame_ok <= 1'b1; st <= S_SYNC; cnt <= CNT_W'(SYNC_BITS - IFS_BITS);
              end else cnt <= cnt + 1'b1;
            end
            default: st <= S_SYNC;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/busframe_rx_chk.sv
`timescale 1ns/1ps
module busframe_rx_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              rx,
  input logic              ack_drive,
  input logic              frame_ok,
  input logic              crc_err,
  input logic              form_err,
  input logic              stuff_err,
  input logic              ext,
  input logic              rtr,
  input logic [28:0]       id,
  input logic [DATA_W-1:0] data
);
  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_ok, crc_err, form_err, stuff_err}));

  // R11
  pulse_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok || crc_err || form_err || stuff_err) |-> $past(bit_en));

  // R10
  ok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);

  // R9
  ack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive) |-> ($past(bit_en) && $past(rx)));

  // R9
  ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_drive && bit_en) |=> !ack_drive);

  // R5
  remote_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && rtr) |-> (data == '0));

  // R3
  short_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !ext) |-> (id[28:11] == '0));
endmodule

bind busframe_rx busframe_rx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/busframe_rx_tb.sv
`timescale 1ns/1ps
module busframe_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, tx = 1'b1;
  logic ack_drive, frame_ok, crc_err, form_err, stuff_err, ext, rtr;
  logic [28:0] id;
  logic [3:0]  dlc;
  logic [63:0] data;
  logic rx;
  assign rx = tx & ~ack_drive;

  busframe_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx(rx), .ack_drive(ack_drive),
    .frame_ok(frame_ok), .crc_err(crc_err), .form_err(form_err), .stuff_err(stuff_err),
    .ext(ext), .rtr(rtr), .id(id), .dlc(dlc), .data(data));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  int n_ok = 0, n_crc = 0, n_form = 0, n_stuff = 0, n_pulse = 0;
  logic [28:0] c_id; logic c_ext, c_rtr; logic [3:0] c_dlc; logic [63:0] c_data;

  always @(negedge clk) if (rst_n) begin
    if (frame_ok) begin
      n_ok++; c_id = id; c_ext = ext; c_rtr = rtr; c_dlc = dlc; c_data = data;
    end
    if (crc_err)   n_crc++;
    if (form_err)  n_form++;
    if (stuff_err) n_stuff++;
    n_pulse += int'(frame_ok) + int'(crc_err) + int'(form_err) + int'(stuff_err);
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  bit raw [0:255];
  bit stf [0:383];
  int nraw, nstf, cdl_i, ack_i, adl_i, eof_i;
  bit saw_ack;
  int s_ok, s_crc, s_form, s_stuff, s_pulse;

  task automatic put_raw(bit b);
    raw[nraw] = b; nraw++;
  endtask

  task automatic build(bit e, logic [28:0] idv, bit r, logic [3:0] d, logic [63:0] pl, bit corrupt);
    logic [14:0] c;
    int n, run;
    bit last;
    nraw = 0;
    put_raw(1'b0);
    if (!e) begin
      for (int i = 10; i >= 0; i--) put_raw(idv[i]);
      put_raw(r); put_raw(1'b0); put_raw(1'b0);
    end else begin
      for (int i = 28; i >= 18; i--) put_raw(idv[i]);
      put_raw(1'b1); put_raw(1'b1);
      for (int i = 17; i >= 0; i--) put_raw(idv[i]);
      put_raw(r); put_raw(1'b0); put_raw(1'b0);
    end
    for (int i = 3; i >= 0; i--) put_raw(d[i]);
    n = r ? 0 : (d > 8 ? 8 : int'(d));
    for (int i = 0; i < 8 * n; i++) put_raw(pl[63 - i]);
    c = '0;
    for (int i = 0; i < nraw; i++)
      c = {c[13:0], 1'b0} ^ ((raw[i] ^ c[14]) ? 15'h4599 : 15'h0);
    for (int i = 14; i >= 0; i--) put_raw(c[i]);
    if (corrupt) raw[6] = ~raw[6];
    nstf = 0; run = 0; last = 1'b0;
    for (int i = 0; i < nraw; i++) begin
      stf[nstf] = raw[i]; nstf++;
      if (i > 0 && raw[i] == last) run++; else run = 1;
      last = raw[i];
      if (run == 5) begin
        stf[nstf] = ~last; nstf++; last = ~last; run = 1;
      end
    end
    cdl_i = nstf; ack_i = nstf + 1; adl_i = nstf + 2; eof_i = nstf + 3;
    for (int i = 0; i < 13; i++) begin stf[nstf] = 1'b1; nstf++; end
  endtask

  task automatic drive_bit(bit b);
    tx = b;
    @(negedge clk); bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic snap();
    s_ok = n_ok; s_crc = n_crc; s_form = n_form; s_stuff = n_stuff; s_pulse = n_pulse;
  endtask

  task automatic send(int bad_i);
    saw_ack = 1'b0;
    for (int i = 0; i < nstf; i++) begin
      if (i == ack_i) saw_ack = ack_drive;
      drive_bit((i == bad_i) ? 1'b0 : stf[i]);
    end
  endtask

  task automatic idle_bits(int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "reset pulses", {60'd0, frame_ok, crc_err, form_err, stuff_err}, 64'd0);
    check("R11", "reset ack_drive", {63'd0, ack_drive}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_bits(11);

    k = 0;
    for (int e = 0; e < 2; e++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 16; d++) begin
          logic [28:0] idv;
          logic [63:0] pl, ex, exid;
          int n;
          idv = e ? 29'(k * 32'h0351_2A67 + 5) : {18'd0, 11'(k * 693 + 1)};
          if (d == 0)  idv = '0;
          if (d == 15) idv = e ? '1 : 29'h7FF;
          for (int j = 0; j < 8; j++) pl[63 - 8*j -: 8] = 8'(k * 29 + j * 71 + 3);
          if (d == 1) pl = '0;
          if (d == 2) pl = '1;
          n = r ? 0 : (d > 8 ? 8 : d);
          ex = (n == 0) ? 64'd0 : (pl & ~(64'hFFFF_FFFF_FFFF_FFFF >> (8 * n)));
          exid = {35'd0, idv};
          build(e[0], idv, r[0], 4'(d), pl, 1'b0);
          snap();
          send(-1);
          check("R10", "frame_ok count", 64'(n_ok - s_ok), 64'd1);
          check("R3", "identifier", {35'd0, c_id}, exid);
          check("R3", "format flag", {63'd0, c_ext}, 64'(e));
          check("R4", "remote flag", {63'd0, c_rtr}, 64'(r));
          check("R5", "length code", {60'd0, c_dlc}, 64'(d));
          check("R5", "payload", c_data, ex);
          check("R9", "ack driven", {63'd0, saw_ack}, 64'd1);
          check("R11", "one pulse per good frame", 64'(n_pulse - s_pulse), 64'd1);
          if (nstf > nraw + 13)
            check("R2", "stuffed frame decoded", 64'(n_ok - s_ok), 64'd1);
          // R1: back-to-back frame after 3 intermission bits is accepted in the next round
          k++;
        end

    // R6 check-sum mismatch
    build(1'b0, 29'h123, 1'b0, 4'd4, 64'hDEAD_BEEF_0102_0304, 1'b1);
    snap(); send(-1);
    check("R6", "crc_err count", 64'(n_crc - s_crc), 64'd1);
    check("R6", "no frame_ok", 64'(n_ok - s_ok), 64'd0);
    check("R9", "no ack on bad sum", {63'd0, saw_ack}, 64'd0);
    idle_bits(11);

    // R7 check-sum delimiter dominant
    build(1'b1, 29'h0ABC_DEF0, 1'b0, 4'd3, 64'h1122_3344_5566_7788, 1'b0);
    snap(); send(cdl_i);
    check("R7", "form_err at sum delimiter", 64'(n_form - s_form), 64'd1);
    check("R7", "no frame_ok", 64'(n_ok - s_ok), 64'd0);
    idle_bits(11);

    // R7 acknowledge delimiter dominant
    snap(); send(adl_i);
    check("R7", "form_err at ack delimiter", 64'(n_form - s_form), 64'd1);
    check("R9", "ack still driven", {63'd0, saw_ack}, 64'd1);
    check("R7", "no frame_ok", 64'(n_ok - s_ok), 64'd0);
    idle_bits(11);

    // R7 last end-of-frame bit dominant
    snap(); send(eof_i + 6);
    check("R7", "form_err at end bit", 64'(n_form - s_form), 64'd1);
    check("R10", "no frame_ok on fault", 64'(n_ok - s_ok), 64'd0);
    idle_bits(11);

    // R8 six equal bits
    snap();
    for (int i = 0; i < 6; i++) drive_bit(1'b0);
    check("R8", "stuff_err count", 64'(n_stuff - s_stuff), 64'd1);
    check("R8", "no frame_ok", 64'(n_ok - s_ok), 64'd0);

    // R1 frame started before idle is ignored
    idle_bits(5);
    build(1'b0, 29'h2AA, 1'b0, 4'd2, 64'hA5C3_0000_0000_0000, 1'b0);
    snap(); send(-1);
    check("R1", "frame before idle ignored", 64'(n_ok - s_ok), 64'd0);
    check("R1", "no pulse while waiting", 64'(n_pulse - s_pulse), 64'd0);
    snap(); send(-1);
    check("R1", "frame after idle accepted", 64'(n_ok - s_ok), 64'd1);
    check("R5", "payload after recovery", c_data, 64'hA5C3_0000_0000_0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule